// File: doc/BRIEF.md
# Receive Polarity Detection and Correction

This block sits in the receive path of a 10 Mb/s twisted-pair port, after the decoder has turned the line signal into discrete events. For every link pulse and every end-of-frame marker it is given a strobe and a tag that says whether the event arrived with inverted polarity on the wire. When a pair is wired backwards, these events keep arriving inverted. The block counts consecutive inverted events and flips its polarity state once enough of them have arrived in a row. While the state is inverted, it drives a data-invert control so the downstream decoder sees corrected data.

Link pulses and end-of-frame markers are counted as two independent runs, each with its own threshold. A frame that ends with the wrong polarity raises a one-cycle receive-error pulse. The number of receive errors seen before correction therefore depends on how link pulses and frames interleave. A tick-driven timeout returns the state to normal when the line has been silent for a full timeout period.

The same thresholds apply in the other direction. Once the state is inverted, a run of events that look inverted relative to the current state switches it back to normal.

Top module: `rx_polarity_corrector`

## Requirements
- R1: After reset, `pol_inv_o`, `data_inv_o` and `rx_er_o` are all 0, and the state is normal.
- R2: An event is mismatched when its tag (1 = arrived inverted on the wire) differs from `pol_inv_o`. `LP_THRESH` (default 8) consecutive mismatched link pulses toggle `pol_inv_o` on the clock edge that samples the last of them.
- R3: `EOF_THRESH` (default 4) consecutive mismatched end-of-frame markers toggle `pol_inv_o` on the clock edge that samples the last of them.
- R4: A matched link pulse clears the link-pulse run, and a matched end-of-frame marker clears the marker run. An event of one kind never changes the run of the other kind.
- R5: `rx_er_o` is high for exactly the one cycle after each end-of-frame strobe that is mismatched against the state held when the strobe was sampled. This includes the marker that causes a toggle. Matched markers and link pulses never raise `rx_er_o`.
- R6: `data_inv_o` is 1 exactly while the state is inverted.
- R7: After `TIMEOUT_TICKS` (default 16) tick strobes with no link pulse, frame start or end-of-frame strobe since the last such activity, the state returns to normal and both runs are cleared. This takes effect on the edge that samples the final tick.
- R8: Any activity strobe in the same cycle as a tick reloads the timeout, so no expiry occurs in that cycle.
- R9: A toggle clears both runs. If both runs reach their threshold in the same cycle, the state toggles only once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lp_valid_i | input | 1 | Link pulse received, one-cycle strobe |
| lp_inv_i | input | 1 | Link pulse arrived inverted on the wire |
| sof_i | input | 1 | Frame start strobe (activity only) |
| eof_valid_i | input | 1 | End-of-frame marker received, one-cycle strobe |
| eof_inv_i | input | 1 | End-of-frame marker arrived inverted on the wire |
| tick_i | input | 1 | Timeout time-base tick |
| pol_inv_o | output | 1 | Polarity state, 1 = inverted |
| data_inv_o | output | 1 | Invert received data downstream |
| rx_er_o | output | 1 | Receive error pulse for a wrongly polarized frame |

## Verification
The sharpest case is a link pulse completing its run in the same cycle as a mismatched end-of-frame marker that also completes its own run. The bench builds seven inverted pulses and three inverted markers, then strobes both together. It expects a single toggle, an error pulse judged against the old state, and, after that, a marker that is now matched and produces neither an error nor a further change. A second overlap puts a tick on the cycle the timeout would expire, together with a link pulse. The bench then checks that the state survives and that a full new period is needed before it falls back to normal.

// File: rtl/pol_pkg.sv
package pol_pkg;
  typedef enum logic {
    POL_NORMAL   = 1'b0,
    POL_INVERTED = 1'b1
  } pol_e;

  localparam int unsigned N_RUNS = 2;  // 0: link pulses, 1: end-of-frame markers
endpackage

// File: rtl/pol_run_counter.sv
module pol_run_counter #(
  parameter int unsigned THRESH = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic evt_i,
  input  logic mismatch_i,
  output logic hit_o
);
  localparam int unsigned CW = $clog2(THRESH + 1);

  logic [CW-1:0] run_q;

  assign hit_o = evt_i && mismatch_i && (run_q == CW'(THRESH - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= '0;
    end else if (clr_i) begin
      run_q <= '0;
    end else if (evt_i) begin
      run_q <= mismatch_i ? run_q + CW'(1) : '0;
    end
  end
endmodule

// File: rtl/pol_timeout.sv
module pol_timeout #(
  parameter int unsigned TICKS = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic tick_i,
  output logic expire_o
);
  localparam int unsigned CW = $clog2(TICKS + 1);

  logic [CW-1:0] cnt_q;

  // reaching zero stops the count; a reload is needed to re-arm
  assign expire_o = tick_i && !load_i && (cnt_q == CW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= CW'(TICKS);
    end else if (load_i) begin
      cnt_q <= CW'(TICKS);
    end else if (tick_i && cnt_q != '0) begin
      cnt_q <= cnt_q - CW'(1);
    end
  end
endmodule

// File: rtl/rx_polarity_corrector.sv
module rx_polarity_corrector #(
  parameter int unsigned LP_THRESH     = 8,
  parameter int unsigned EOF_THRESH    = 4,
  parameter int unsigned TIMEOUT_TICKS = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lp_valid_i,
  input  logic lp_inv_i,
  input  logic sof_i,
  input  logic eof_valid_i,
  input  logic eof_inv_i,
  input  logic tick_i,
  output logic pol_inv_o,
  output logic data_inv_o,
  output logic rx_er_o
);
  import pol_pkg::*;

  pol_e state_q;
  logic rx_er_q;
  logic activity;
  logic expire;
  logic toggle;
  logic clr_runs;
  logic [N_RUNS-1:0] evt, mis, hit;

  assign evt[0] = lp_valid_i;
  assign mis[0] = lp_inv_i ^ state_q;
  assign evt[1] = eof_valid_i;
  assign mis[1] = eof_inv_i ^ state_q;

  genvar g;
  generate
    for (g = 0; g < N_RUNS; g++) begin : g_run
      pol_run_counter #(
        .THRESH(g == 0 ? LP_THRESH : EOF_THRESH)
      ) i_run (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .clr_i     (clr_runs),
        .evt_i     (evt[g]),
        .mismatch_i(mis[g]),
        .hit_o     (hit[g])
      );
    end
  endgenerate

  assign activity = lp_valid_i | eof_valid_i | sof_i;

  pol_timeout #(
    .TICKS(TIMEOUT_TICKS)
  ) i_timeout (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (activity),
    .tick_i  (tick_i),
    .expire_o(expire)
  );

  assign toggle   = |hit;  // both hitting together still flips once
  assign clr_runs = toggle | expire;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= POL_NORMAL;
      rx_er_q <= 1'b0;
    end else begin
      if (expire)      state_q <= POL_NORMAL;
      else if (toggle) state_q <= (state_q == POL_NORMAL) ? POL_INVERTED : POL_NORMAL;
      rx_er_q <= evt[1] & mis[1];
    end
  end

  assign pol_inv_o  = (state_q == POL_INVERTED);
  assign data_inv_o = (state_q == POL_INVERTED);
  assign rx_er_o    = rx_er_q;
endmodule

// File: rtl/rx_polarity_corrector_chk.sv
module rx_polarity_corrector_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic lp_valid_i,
  input logic lp_inv_i,
  input logic sof_i,
  input logic eof_valid_i,
  input logic eof_inv_i,
  input logic tick_i,
  input logic pol_inv_o,
  input logic data_inv_o,
  input logic rx_er_o
);
  assert_er_cause_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_er_o |-> $past(eof_valid_i));

  assert_er_on_mismatch_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eof_valid_i && (eof_inv_i != pol_inv_o)) |=> rx_er_o);

  assert_rise_needs_event_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pol_inv_o) |-> $past(lp_valid_i || eof_valid_i));

  assert_matched_lp_holds_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lp_valid_i && (lp_inv_i == pol_inv_o) && !eof_valid_i && !tick_i) |=> $stable(pol_inv_o));

  assert_data_inv_tracks_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(pol_inv_o) |-> !$stable(data_inv_o));

  assert_tick_only_no_rise_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !lp_valid_i && !eof_valid_i) |=> !$rose(pol_inv_o));
endmodule

bind rx_polarity_corrector rx_polarity_corrector_chk i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .lp_valid_i (lp_valid_i),
  .lp_inv_i   (lp_inv_i),
  .sof_i      (sof_i),
  .eof_valid_i(eof_valid_i),
  .eof_inv_i  (eof_inv_i),
  .tick_i     (tick_i),
  .pol_inv_o  (pol_inv_o),
  .data_inv_o (data_inv_o),
  .rx_er_o    (rx_er_o)
);

// File: tb/test_rx_polarity_corrector.sv
module test_rx_polarity_corrector;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic lp_valid_i = 1'b0, lp_inv_i = 1'b0, sof_i = 1'b0;
  logic eof_valid_i = 1'b0, eof_inv_i = 1'b0, tick_i = 1'b0;
  logic pol_inv_o, data_inv_o, rx_er_o;

  int n_tests = 0;
  int n_fail  = 0;

  always #4 clk = ~clk;  // 125 MHz

  rx_polarity_corrector i_rx_polarity_corrector (
    .clk_i(clk), .rst_ni(rst_ni),
    .lp_valid_i(lp_valid_i), .lp_inv_i(lp_inv_i), .sof_i(sof_i),
    .eof_valid_i(eof_valid_i), .eof_inv_i(eof_inv_i), .tick_i(tick_i),
    .pol_inv_o(pol_inv_o), .data_inv_o(data_inv_o), .rx_er_o(rx_er_o)
  );

  // {lp_v, lp_inv, eof_v, eof_inv, sof, tick, exp_pol, exp_er}
  localparam logic [7:0] VEC [16] = '{
    8'b00_11_00_01,  // inverted marker -> error        R5
    8'b00_11_00_01,
    8'b00_10_00_00,  // matched marker clears run        R4
    8'b00_11_00_01,
    8'b00_11_00_01,
    8'b00_11_00_01,
    8'b00_11_00_11,  // 4th in a row: toggle + error      R3
    8'b00_11_00_10,  // now matched                       R5
    8'b00_00_10_10,  // frame start only
    8'b00_10_00_11,  // raw normal now mismatched
    8'b11_00_00_10,  // matched pulse leaves marker run   R4
    8'b00_10_00_11,
    8'b00_10_00_11,
    8'b00_10_00_01,  // 4th: back to normal               R3
    8'b00_10_00_00,
    8'b00_00_01_00   // lone tick
  };

  task automatic check(input string req, input logic got, input logic exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0b expected %0b", req, got, exp);
    end
  endtask

  task automatic step(input logic lv, input logic li, input logic ev, input logic ei,
                      input logic sf, input logic tk);
    @(negedge clk);
    lp_valid_i = lv; lp_inv_i = li; eof_valid_i = ev; eof_inv_i = ei; sof_i = sf; tick_i = tk;
    @(posedge clk);
    #2;
    lp_valid_i = 0; lp_inv_i = 0; eof_valid_i = 0; eof_inv_i = 0; sof_i = 0; tick_i = 0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 1);
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 pol", pol_inv_o, 1'b0);
    check("R1 inv", data_inv_o, 1'b0);
    check("R1 er", rx_er_o, 1'b0);
    rst_ni = 1'b1;

    foreach (VEC[k]) begin
      step(VEC[k][7], VEC[k][6], VEC[k][5], VEC[k][4], VEC[k][3], VEC[k][2]);
      check("R3/R4 table pol", pol_inv_o, VEC[k][1]);
      check("R5 table er", rx_er_o, VEC[k][0]);
    end

    // R2 / R4: pulse run, broken by a matched pulse
    for (int i = 0; i < 7; i++) step(1, 1, 0, 0, 0, 0);
    step(1, 0, 0, 0, 0, 0);
    for (int i = 0; i < 7; i++) begin
      step(1, 1, 0, 0, 0, 0);
      check("R5 pulse no er", rx_er_o, 1'b0);
    end
    check("R4 pulse run cleared", pol_inv_o, 1'b0);
    step(1, 1, 0, 0, 0, 0);
    check("R2 eighth pulse", pol_inv_o, 1'b1);
    check("R6 data inv", data_inv_o, 1'b1);

    // R7 / R8: timeout with reload mid-way
    ticks(10);
    step(1, 1, 0, 0, 0, 0);
    ticks(15);
    check("R8 reload kept state", pol_inv_o, 1'b1);
    step(0, 0, 0, 0, 0, 1);
    check("R7 expiry", pol_inv_o, 1'b0);
    check("R6 data inv cleared", data_inv_o, 1'b0);

    // R7: expiry clears runs
    for (int i = 0; i < 3; i++) step(0, 0, 1, 1, 0, 0);
    ticks(16);
    step(0, 0, 1, 1, 0, 0);
    check("R7 runs cleared", pol_inv_o, 1'b0);
    step(0, 0, 1, 0, 0, 0);

    // R9: both runs hit together
    for (int i = 0; i < 7; i++) step(1, 1, 0, 0, 0, 0);
    for (int i = 0; i < 3; i++) step(0, 0, 1, 1, 0, 0);
    check("R9 before", pol_inv_o, 1'b0);
    step(1, 1, 1, 1, 0, 0);
    check("R9 single toggle", pol_inv_o, 1'b1);
    check("R5 er on old state", rx_er_o, 1'b1);
    step(0, 0, 1, 1, 0, 0);
    check("R9 matched after", pol_inv_o, 1'b1);
    check("R5 no er matched", rx_er_o, 1'b0);

    // R8: activity on expiring tick
    ticks(15);
    step(1, 1, 0, 0, 0, 1);
    check("R8 no expiry", pol_inv_o, 1'b1);
    ticks(15);
    check("R8 full period", pol_inv_o, 1'b1);
    step(0, 0, 0, 0, 0, 1);
    check("R7 late expiry", pol_inv_o, 1'b0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule